// File: doc/BRIEF.md
# Receive Event Counter and Interrupt Aggregator

This block gathers error and status events from a T1 receive path into one maskable interrupt line. It keeps five free-running 8-bit event counters, for frame-alignment changes, bipolar violations, PRBS errors, PRBS multiframes and multiframes out of sync. A counter raises a sticky status bit at the moment it wraps from 0xFF to 0x00. It also takes framer condition inputs and two timer levels. The conditions are loss of terminal frame sync, loss of multiframe sync, a framing bit error that counts only while the framer is in terminal frame sync, and a signaling change. The timer levels are a one-second and a two-second level, and only their rising edges count.

Eleven sticky status bits are gated by a mask register, where a 1 blocks a source, and ORed into a registered, active-high interrupt. Software reads the status word over a small synchronous register bus, and the read clears the word. An event arriving in the same cycle as that read survives it. The counters and the mask are also readable on the same bus.

Top module: `t1_rx_event_irq`

## Requirements
- R1: After synchronous reset the status word is 0, the mask word is 0x7FF (all sources masked), all counters read 0, `irq` is 0 and `bus_rdata` is 0.
- R2: Counter i (0..4) increments by one on each cycle in which `cnt_inc[i]` is high and wraps freely from 0xFF to 0x00. Its value reads at bus address 2+i in `bus_rdata[7:0]`, with the upper bits zero.
- R3: Status bit i (0..4) is set when counter i steps from 0xFF to 0x00, and only then.
- R4: Status bit 5 (loss of terminal frame sync) and bit 6 (loss of multiframe sync) are set on every cycle in which their condition input is high.
- R5: Status bit 7 is set by `fbit_err` only in a cycle where `in_term_sync` is also high. A framing bit error outside terminal frame sync has no effect.
- R6: Status bit 8 is set on each cycle `sig_change` is high.
- R7: Status bit 9 is set on a low-to-high transition of `sec1_lvl`, and bit 10 on a low-to-high transition of `sec2_lvl`. A level that stays high does not set the bit again after it has been cleared.
- R8: A read (`bus_rd`) at address 0 returns the status word in `bus_rdata[10:0]` on the next cycle and clears every status bit. `bus_rdata` is 0 in any cycle after a cycle without a read.
- R9: If a source sets a status bit in the same cycle as a status-clearing read, the bit stays set.
- R10: A write (`bus_wr`) at address 1 loads the mask from `bus_wdata[10:0]`. The mask reads back at address 1. A mask bit of 1 blocks its source and 0 lets it through.
- R11: `irq` equals the OR over all bits of (status AND NOT mask), delayed by one register stage.
- R12: Reads at addresses 7 return 0, and writes to any address other than 1 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_inc | input | 5 | Per-counter increment strobes (0 frame-align change, 1 bipolar violation, 2 PRBS error, 3 PRBS multiframe, 4 multiframe out of sync) |
| loss_tfs | input | 1 | Loss of terminal frame sync condition |
| loss_mfs | input | 1 | Loss of multiframe sync condition |
| fbit_err | input | 1 | Framing bit error strobe |
| in_term_sync | input | 1 | Framer is in terminal frame sync |
| sig_change | input | 1 | Signaling bit change strobe |
| sec1_lvl | input | 1 | One-second timer level |
| sec2_lvl | input | 1 | Two-second timer level |
| bus_addr | input | 3 | Register address |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data |
| irq | output | 1 | Registered active-high interrupt |

## Verification
The assertions check on every cycle that a counter steps by one and wraps to zero, and that the matching status bit follows a wrap and nothing else. They also check that a clearing read drops only the bits with no new event, that a loss condition keeps its bit set, that a framing bit error outside sync and a steady timer level leave their bits clear, and that `irq` tracks the masked status one cycle later. The bench scenarios are needed for what the assertions cannot see: the values returned over the bus and their one-cycle latency, mask write and read-back, and ignored writes and unmapped reads. They also cover long runs of 256 strobes up to a wrap and mixed random traffic in which reads collide with events.

// File: rtl/t1ev_pkg.sv
package t1ev_pkg;
  localparam int NUM_CNT  = 5;
  localparam int NUM_SRC  = 11;
  // status bit positions
  localparam int BIT_LTFS = 5;
  localparam int BIT_LMFS = 6;
  localparam int BIT_FBE  = 7;
  localparam int BIT_SIG  = 8;
  localparam int BIT_S1   = 9;
  localparam int BIT_S2   = 10;
  // register addresses
  localparam int ADR_STAT = 0;
  localparam int ADR_MASK = 1;
  localparam int ADR_CNT0 = 2;
endpackage

// File: rtl/t1ev_wrap_counter.sv
module t1ev_wrap_counter #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          inc,
  output logic [CW-1:0] count,
  output logic          wrap
);
  always_ff @(posedge clk) begin
    if (rst)      count <= '0;
    else if (inc) count <= count + 1'b1;
  end

  assign wrap = inc && (&count);

  // R2: free wrap back to zero
  a_r2_wrap_to_zero: assert property (@(posedge clk) disable iff (rst)
    (inc && (&count)) |=> (count == '0));
  // R2: single step otherwise
  a_r2_step: assert property (@(posedge clk) disable iff (rst)
    (inc && !(&count)) |=> (count == $past(count) + 1'b1));
  a_r2_hold: assert property (@(posedge clk) disable iff (rst)
    !inc |=> $stable(count));
endmodule

// File: rtl/t1ev_src_qualify.sv
module t1ev_src_qualify (
  input  logic       clk,
  input  logic       loss_tfs,
  input  logic       loss_mfs,
  input  logic       fbit_err,
  input  logic       in_term_sync,
  input  logic       sig_change,
  input  logic       sec1_lvl,
  input  logic       sec2_lvl,
  output logic [5:0] ev
);
  logic s1_prev, s2_prev;

  // previous levels track the inputs even in reset, so a level held
  // high across reset release is not seen as a fresh edge
  always_ff @(posedge clk) begin
    s1_prev <= sec1_lvl;
    s2_prev <= sec2_lvl;
  end

  always_comb begin
    ev[0] = loss_tfs;
    ev[1] = loss_mfs;
    ev[2] = fbit_err && in_term_sync;
    ev[3] = sig_change;
    ev[4] = sec1_lvl && !s1_prev;
    ev[5] = sec2_lvl && !s2_prev;
  end
endmodule

// File: rtl/t1ev_status_bank.sv
module t1ev_status_bank #(
  parameter int N = 11
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set,
  input  logic         clr,
  input  logic         mask_wr,
  input  logic [N-1:0] mask_wdata,
  output logic [N-1:0] status,
  output logic [N-1:0] mask,
  output logic         irq
);
  always_ff @(posedge clk) begin
    if (rst) begin
      status <= '0;
      mask   <= '1;
      irq    <= 1'b0;
    end else begin
      status <= (status & ~{N{clr}}) | set;
      if (mask_wr) mask <= mask_wdata;
      irq    <= |(status & ~mask);
    end
  end

  // R11: registered interrupt follows the masked status
  a_r11_irq_high: assert property (@(posedge clk) disable iff (rst)
    (|(status & ~mask)) |=> irq);
  a_r11_irq_low: assert property (@(posedge clk) disable iff (rst)
    !(|(status & ~mask)) |=> !irq);

  for (genvar i = 0; i < N; i++) begin : g_bit
    // R9: a new event beats a clearing read
    a_r9_set_wins: assert property (@(posedge clk) disable iff (rst)
      set[i] |=> status[i]);
    // R8: a read clears bits with no new event
    a_r8_clear: assert property (@(posedge clk) disable iff (rst)
      (clr && !set[i]) |=> !status[i]);
    a_r8_sticky: assert property (@(posedge clk) disable iff (rst)
      (status[i] && !clr) |=> status[i]);
  end
endmodule

// File: rtl/t1_rx_event_irq.sv
module t1_rx_event_irq
  import t1ev_pkg::*;
#(
  parameter int CNT_W  = 8,
  parameter int DATA_W = 16,
  parameter int ADDR_W = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_CNT-1:0] cnt_inc,
  input  logic               loss_tfs,
  input  logic               loss_mfs,
  input  logic               fbit_err,
  input  logic               in_term_sync,
  input  logic               sig_change,
  input  logic               sec1_lvl,
  input  logic               sec2_lvl,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic               bus_rd,
  input  logic               bus_wr,
  input  logic [DATA_W-1:0]  bus_wdata,
  output logic [DATA_W-1:0]  bus_rdata,
  output logic               irq
);
  localparam int NCOND = NUM_SRC - NUM_CNT;

  logic [NUM_CNT-1:0][CNT_W-1:0] cnt;
  logic [NUM_CNT-1:0]            wrap;
  logic [NCOND-1:0]              cond_ev;
  logic [NUM_SRC-1:0]            set_vec;
  logic [NUM_SRC-1:0]            status;
  logic [NUM_SRC-1:0]            mask;
  logic                          stat_rd;
  logic                          mask_wr;
  logic [DATA_W-1:0]             rd_mux;
  logic                          unused_wdata;

  for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
    t1ev_wrap_counter #(.CW(CNT_W)) u_cnt (
      .clk   (clk),
      .rst   (rst),
      .inc   (cnt_inc[i]),
      .count (cnt[i]),
      .wrap  (wrap[i])
    );
  end

  t1ev_src_qualify u_qual (
    .clk          (clk),
    .loss_tfs     (loss_tfs),
    .loss_mfs     (loss_mfs),
    .fbit_err     (fbit_err),
    .in_term_sync (in_term_sync),
    .sig_change   (sig_change),
    .sec1_lvl     (sec1_lvl),
    .sec2_lvl     (sec2_lvl),
    .ev           (cond_ev)
  );

  assign set_vec = {cond_ev, wrap};
  assign stat_rd = bus_rd && (bus_addr == ADDR_W'(ADR_STAT));
  assign mask_wr = bus_wr && (bus_addr == ADDR_W'(ADR_MASK));
  assign unused_wdata = ^bus_wdata[DATA_W-1:NUM_SRC];

  t1ev_status_bank #(.N(NUM_SRC)) u_bank (
    .clk        (clk),
    .rst        (rst),
    .set        (set_vec),
    .clr        (stat_rd),
    .mask_wr    (mask_wr),
    .mask_wdata (bus_wdata[NUM_SRC-1:0]),
    .status     (status),
    .mask       (mask),
    .irq        (irq)
  );

  always_comb begin
    rd_mux = '0;
    if (bus_addr == ADDR_W'(ADR_STAT)) rd_mux[NUM_SRC-1:0] = status;
    if (bus_addr == ADDR_W'(ADR_MASK)) rd_mux[NUM_SRC-1:0] = mask;
    for (int i = 0; i < NUM_CNT; i++) begin
      if (bus_addr == ADDR_W'(ADR_CNT0 + i)) rd_mux[CNT_W-1:0] = cnt[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
    else             bus_rdata <= '0;
  end

  // R3: a wrap bit follows only a 0xFF -> 0x00 step
  for (genvar i = 0; i < NUM_CNT; i++) begin : g_chk
    a_r3_wrap_sets: assert property (@(posedge clk) disable iff (rst)
      (cnt_inc[i] && (&cnt[i])) |=> status[i]);
    a_r3_no_false_wrap: assert property (@(posedge clk) disable iff (rst)
      (!status[i] && !(cnt_inc[i] && (&cnt[i]))) |=> !status[i]);
  end

  // R4: loss conditions keep their bits set
  a_r4_loss_tfs: assert property (@(posedge clk) disable iff (rst)
    loss_tfs |=> status[BIT_LTFS]);
  a_r4_loss_mfs: assert property (@(posedge clk) disable iff (rst)
    loss_mfs |=> status[BIT_LMFS]);
  // R5: framing bit error outside sync is ignored
  a_r5_fbit_gated: assert property (@(posedge clk) disable iff (rst)
    (!status[BIT_FBE] && !(fbit_err && in_term_sync)) |=> !status[BIT_FBE]);
  // R7: a steady timer level raises nothing
  a_r7_sec1_steady: assert property (@(posedge clk) disable iff (rst)
    (sec1_lvl && $past(sec1_lvl) && stat_rd) |=> !status[BIT_S1]);
  a_r7_sec2_steady: assert property (@(posedge clk) disable iff (rst)
    (sec2_lvl && $past(sec2_lvl) && stat_rd) |=> !status[BIT_S2]);
  // R8: no read, no data
  a_r8_idle_zero: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> (bus_rdata == '0));
endmodule

// File: tb/tb_t1_rx_event_irq.sv
`timescale 1ns/1ps
module tb_t1_rx_event_irq;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [4:0]  cnt_inc = '0;
  logic        loss_tfs = 0, loss_mfs = 0, fbit_err = 0, in_term_sync = 0;
  logic        sig_change = 0, sec1_lvl = 0, sec2_lvl = 0;
  logic [2:0]  bus_addr = '0;
  logic        bus_rd = 0, bus_wr = 0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        irq;

  int tests = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  t1_rx_event_irq dut (
    .clk(clk), .rst(rst), .cnt_inc(cnt_inc), .loss_tfs(loss_tfs),
    .loss_mfs(loss_mfs), .fbit_err(fbit_err), .in_term_sync(in_term_sync),
    .sig_change(sig_change), .sec1_lvl(sec1_lvl), .sec2_lvl(sec2_lvl),
    .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  // expected state, from the requirements
  logic [10:0] m_st, m_mask;
  logic [7:0]  m_cnt [5];
  logic        m_p1, m_p2, m_irq;
  logic [15:0] m_rd;

  function automatic logic [15:0] rdval(input logic [2:0] a);
    if (a == 3'd0) return {5'd0, m_st};
    if (a == 3'd1) return {5'd0, m_mask};
    if (a >= 3'd2 && a <= 3'd6) return {8'd0, m_cnt[a - 3'd2]};
    return 16'd0;
  endfunction

  always @(posedge clk) begin
    logic [10:0] set;
    m_p1 <= sec1_lvl;
    m_p2 <= sec2_lvl;
    if (rst) begin
      m_st <= '0; m_mask <= '1; m_irq <= 0; m_rd <= '0;
      for (int i = 0; i < 5; i++) m_cnt[i] <= '0;
    end else begin
      set = '0;
      for (int i = 0; i < 5; i++) begin
        if (cnt_inc[i] && m_cnt[i] == 8'hFF) set[i] = 1'b1;
        if (cnt_inc[i]) m_cnt[i] <= m_cnt[i] + 8'd1;
      end
      set[5]  = loss_tfs;
      set[6]  = loss_mfs;
      set[7]  = fbit_err && in_term_sync;
      set[8]  = sig_change;
      set[9]  = sec1_lvl && !m_p1;
      set[10] = sec2_lvl && !m_p2;
      m_st  <= ((bus_rd && bus_addr == 3'd0) ? 11'd0 : m_st) | set;
      if (bus_wr && bus_addr == 3'd1) m_mask <= bus_wdata[10:0];
      m_irq <= |(m_st & ~m_mask);
      m_rd  <= bus_rd ? rdval(bus_addr) : 16'd0;
    end
  end

  // one clock, then compare at the falling edge
  task automatic step(input string tag);
    @(posedge clk);
    @(negedge clk);
    tests++;
    if (bus_rdata !== m_rd) begin
      fails++;
      $display("FAIL %s rdata actual=%h expected=%h", tag, bus_rdata, m_rd);
    end
    tests++;
    if (irq !== m_irq) begin
      fails++;
      $display("FAIL %s irq actual=%b expected=%b", tag, irq, m_irq);
    end
  endtask

  task automatic idle();
    cnt_inc = '0; loss_tfs = 0; loss_mfs = 0; fbit_err = 0;
    sig_change = 0; bus_rd = 0; bus_wr = 0;
  endtask

  task automatic rd(input logic [2:0] a, input string tag);
    bus_rd = 1; bus_addr = a; step(tag); bus_rd = 0;
    step(tag);
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d, input string tag);
    bus_wr = 1; bus_addr = a; bus_wdata = d; step(tag); bus_wr = 0;
  endtask

  // explicit literal checks (independent of the model)
  task automatic expect_rd(input logic [2:0] a, input logic [15:0] e, input string tag);
    bus_rd = 1; bus_addr = a; step(tag); bus_rd = 0;
    tests++;
    if (bus_rdata !== e) begin
      fails++;
      $display("FAIL %s addr %0d actual=%h expected=%h", tag, a, bus_rdata, e);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_7101));
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1: reset values
    expect_rd(3'd0, 16'h0000, "R1 status");
    expect_rd(3'd1, 16'h07FF, "R1 mask");
    for (int a = 2; a < 7; a++) expect_rd(3'(a), 16'h0000, "R1 counter");
    tests++;
    if (irq !== 1'b0) begin fails++; $display("FAIL R1 irq actual=%b expected=0", irq); end

    // R10: unmask everything, read back
    wr(3'd1, 16'h0000, "R10 mask write");
    expect_rd(3'd1, 16'h0000, "R10 mask readback");

    // R2/R3: 255 strobes on counter 1, no wrap yet
    for (int k = 0; k < 255; k++) begin cnt_inc = 5'b00010; step("R2 count"); end
    cnt_inc = '0;
    expect_rd(3'd3, 16'h00FF, "R2 count 255");
    expect_rd(3'd0, 16'h0000, "R3 no early wrap");
    cnt_inc = 5'b00010; step("R3 wrap");
    cnt_inc = '0; step("R11 irq");
    tests++;
    if (irq !== 1'b1) begin fails++; $display("FAIL R11 irq actual=%b expected=1", irq); end
    expect_rd(3'd3, 16'h0000, "R2 wrapped to 0");
    expect_rd(3'd0, 16'h0002, "R3 wrap bit 1");
    expect_rd(3'd0, 16'h0000, "R8 cleared");

    // R5: framing bit error outside sync ignored, inside sync counted
    in_term_sync = 0; fbit_err = 1; step("R5 out of sync"); fbit_err = 0;
    expect_rd(3'd0, 16'h0000, "R5 ignored");
    in_term_sync = 1; fbit_err = 1; step("R5 in sync"); fbit_err = 0;
    expect_rd(3'd0, 16'h0080, "R5 counted");

    // R4/R9: loss condition held across a clearing read
    loss_tfs = 1; step("R4");
    expect_rd(3'd0, 16'h0020, "R4 loss set");
    expect_rd(3'd0, 16'h0020, "R9 set wins over clear");
    loss_tfs = 0; step("R4");
    expect_rd(3'd0, 16'h0020, "R4 last");
    expect_rd(3'd0, 16'h0000, "R4 gone");
    loss_mfs = 1; step("R4 mfs"); loss_mfs = 0;
    sig_change = 1; step("R6"); sig_change = 0;
    expect_rd(3'd0, 16'h0140, "R6 R4 bits 8 and 6");

    // R7: timer edge once, steady level not again
    sec1_lvl = 1; step("R7 rise");
    expect_rd(3'd0, 16'h0200, "R7 sec1 edge");
    step("R7 steady");
    expect_rd(3'd0, 16'h0000, "R7 no repeat");
    sec1_lvl = 0; sec2_lvl = 1; step("R7 sec2");
    expect_rd(3'd0, 16'h0400, "R7 sec2 edge");
    sec2_lvl = 0;

    // R10: masked source gives no irq
    wr(3'd1, 16'hFFFF, "R10 mask all");
    expect_rd(3'd1, 16'h07FF, "R10 mask width");
    sig_change = 1; step("R10"); sig_change = 0; step("R10"); step("R10");
    tests++;
    if (irq !== 1'b0) begin fails++; $display("FAIL R10 masked irq actual=%b expected=0", irq); end
    wr(3'd1, 16'hFEFF, "R10 unmask bit 8"); step("R11"); step("R11");
    tests++;
    if (irq !== 1'b1) begin fails++; $display("FAIL R10 unmasked irq actual=%b expected=1", irq); end

    // R12: writes elsewhere ignored, address 7 reads zero
    wr(3'd0, 16'hFFFF, "R12 write status"); wr(3'd4, 16'h00AA, "R12 write cnt");
    expect_rd(3'd1, 16'h06FF, "R12 mask unchanged");
    expect_rd(3'd4, 16'h0000, "R12 counter unchanged");
    expect_rd(3'd7, 16'h0000, "R12 unmapped");

    // random traffic against the expected model
    for (int n = 0; n < 6000; n++) begin
      idle();
      cnt_inc      = 5'($urandom) & 5'($urandom);
      loss_tfs     = ($urandom_range(0, 19) == 0);
      loss_mfs     = ($urandom_range(0, 19) == 0);
      fbit_err     = ($urandom_range(0, 9) == 0);
      in_term_sync = ($urandom_range(0, 3) != 0);
      sig_change   = ($urandom_range(0, 15) == 0);
      if ($urandom_range(0, 30) == 0) sec1_lvl = ~sec1_lvl;
      if ($urandom_range(0, 50) == 0) sec2_lvl = ~sec2_lvl;
      bus_addr     = 3'($urandom);
      bus_rd       = ($urandom_range(0, 3) == 0);
      bus_wr       = ($urandom_range(0, 40) == 0);
      bus_wdata    = 16'($urandom);
      step("R2 R3 R8 R9 R11 random");
    end
    idle();
    step("end");

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule